// File: doc/BRIEF.md
# Boundary-Pausing Simple-DMA Write Engine

This block is the address engine for the single-address DMA mode of an SD host controller. Software sets a start address and writes the block geometry word, which holds the block length, the boundary code and the block count. Writing a nonzero block count arms the transfer. The engine then accepts 32-bit words from the card-side buffer and turns each one into a memory write at a rising address. Each word advances the address by four. At the end of every block the engine decrements the block count. When the count reaches zero, the engine reports transfer-complete.

The address space is split into equal windows, each 4 KiB shifted left by the boundary code. When the next address would fall on a window edge, the engine stops taking data and raises a DMA status flag. Software then writes the system address register. Writing any value restarts the transfer from that value. Writing back the value the register currently reads continues the transfer with nothing lost and nothing repeated.

The register window is 256 bytes wide and repeats across the whole decoded range.

Top module: `sdma_engine`

## Requirements
- R1: After reset, the registers at offsets 0x00, 0x04 and 0x30 read zero, and buf_ready, mem_wr_valid and irq are low.
- R2: Register decode uses only reg_addr[7:0]. Higher address bits select the same register. Unmapped offsets read zero and ignore writes.
- R3: While idle, a write to offset 0x04 loads the block length (bits 11:0), the boundary code (bits 14:12) and the block count (bits 31:16). A nonzero count starts the transfer and raises buf_ready. A zero count leaves the engine idle.
- R4: Each word taken (buf_valid and buf_ready high at a clock edge) produces exactly one mem_wr_valid pulse on the next cycle. That pulse carries the current system address and the word. The address at offset 0x00 then advances by 4.
- R5: After each block-length worth of bytes (block length divided by 4 words), the count at offset 0x04 bits 31:16 drops by one.
- R6: When the count reaches zero, status bit 1 at offset 0x30 is set and the engine returns to idle with buf_ready low.
- R7: The boundary size is 4096 << code. When the address after a taken word is a multiple of that size, the engine pauses and sets status bit 3. While paused, buf_ready stays low, no memory write is issued, and offset 0x00 reads the next address.
- R8: While paused, a write to offset 0x00 loads that address and resumes the transfer. Writing back the value read continues the transfer without a gap.
- R9: If the last word of a transfer also ends on a boundary, only completion is reported and status bit 3 stays clear.
- R10: Status bits 1 and 3 are cleared by writing 1 to that bit. Writing 0 has no effect. irq is high exactly while either status bit is set.
- R11: While the engine is running (not paused), writes to offsets 0x00 and 0x04 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | REG_AW | Register address; only the low 8 bits are decoded |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the addressed register (combinational) |
| buf_valid | input | 1 | Buffer offers a data word |
| buf_data | input | DATA_W | Data word from the card-side buffer |
| buf_ready | output | 1 | Engine takes a word this cycle |
| mem_wr_valid | output | 1 | Memory write request |
| mem_wr_addr | output | ADDR_W | Memory write byte address |
| mem_wr_data | output | DATA_W | Memory write data |
| irq | output | 1 | OR of the pending status bits |

## Verification
Most internal faults appear at the memory write port within one cycle. A wrong address counter shows up as a bad mem_wr_addr on the very next write. A wrong boundary mask shows up at the first window edge, either as a write that should not have happened or as a pause that comes too early. A wrong block counter shows up at the next block end, in the count read back from offset 0x04. The same fault also appears at the last word, as completion arriving too early or too late. Faults in status handling are visible on irq and at offset 0x30 immediately after the event or clear write that should have changed them.

// File: rtl/sdma_pkg.sv
package sdma_pkg;

    localparam logic [7:0] OFF_SYS = 8'h00;
    localparam logic [7:0] OFF_BLK = 8'h04;
    localparam logic [7:0] OFF_STS = 8'h30;

    localparam int unsigned STS_DONE_BIT = 1;
    localparam int unsigned STS_DMA_BIT  = 3;
    localparam int unsigned BND_BASE_LOG2 = 12;

    typedef enum logic [1:0] {
        XS_IDLE  = 2'd0,
        XS_RUN   = 2'd1,
        XS_PAUSE = 2'd2
    } xfer_state_e;

    // Bits 14:12 = boundary code, bits 11:0 = block length in bytes.
    typedef struct packed {
        logic [2:0]  bnd_code;
        logic [11:0] blen;
    } blk_cfg_t;

    typedef struct packed {
        logic done;
        logic pause;
    } xfer_evt_t;

    // Low-bit mask of one boundary window: (4 KiB << code) - 1.
    function automatic logic [63:0] bound_mask(input logic [2:0] code);
        logic [63:0] span;
        span = 64'd1 << (BND_BASE_LOG2 + int'(code));
        return span - 64'd1;
    endfunction

endpackage

// File: rtl/sdma_regfile.sv
module sdma_regfile
    import sdma_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        off,
    input  logic              reg_wr,
    input  logic [15:0]       wdata_lo,
    input  logic              idle,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [CNT_W-1:0]  blk_cnt,
    input  xfer_evt_t         evt,
    output logic              wr_sys,
    output logic              wr_blk,
    output blk_cfg_t          cfg,
    output logic [31:0]       rdata,
    output logic              irq
);

    blk_cfg_t cfg_q;
    logic     done_q;
    logic     dma_q;
    logic     wr_sts;
    logic     unused_wd;

    assign unused_wd = wdata_lo[15];

    assign wr_sys = reg_wr && (off == OFF_SYS);
    assign wr_blk = reg_wr && (off == OFF_BLK);
    assign wr_sts = reg_wr && (off == OFF_STS);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            done_q <= 1'b0;
            dma_q  <= 1'b0;
        end else begin
            if (wr_blk && idle) begin
                cfg_q <= blk_cfg_t'(wdata_lo[14:0]);
            end
            // Setting beats clearing in the same cycle.
            if (evt.done) begin
                done_q <= 1'b1;
            end else if (wr_sts && wdata_lo[STS_DONE_BIT]) begin
                done_q <= 1'b0;
            end
            if (evt.pause) begin
                dma_q <= 1'b1;
            end else if (wr_sts && wdata_lo[STS_DMA_BIT]) begin
                dma_q <= 1'b0;
            end
        end
    end

    always_comb begin
        rdata = '0;
        unique case (off)
            OFF_SYS: rdata = 32'(cur_addr);
            OFF_BLK: rdata = (32'(blk_cnt) << 16) | 32'(cfg_q);
            OFF_STS: begin
                rdata[STS_DONE_BIT] = done_q;
                rdata[STS_DMA_BIT]  = dma_q;
            end
            default: rdata = '0;
        endcase
    end

    assign cfg = cfg_q;
    assign irq = done_q | dma_q;

    // R6: completion flag only rises after a completion event
    p_done_cause_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(done_q) |-> $past(evt.done));

    // R7: DMA flag only rises after a boundary pause event
    p_pause_cause_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(dma_q) |-> $past(evt.pause));

    // R9: the final word never also raises the DMA flag
    p_done_no_pause_r9: assert property (@(posedge clk) disable iff (rst)
        evt.done |=> !$rose(dma_q));

endmodule

// File: rtl/sdma_xfer_ctrl.sv
module sdma_xfer_ctrl
    import sdma_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_sys,
    input  logic              wr_blk,
    input  logic [31:0]       wdata,
    input  blk_cfg_t          cfg,
    input  logic              buf_valid,
    output logic              buf_ready,
    output logic              accept,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [CNT_W-1:0]  blk_cnt,
    output logic              idle,
    output xfer_evt_t         evt
);

    localparam int unsigned STEP = DATA_W / 8;

    xfer_state_e       state;
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [11:0]       byte_q;

    logic [ADDR_W-1:0] next_addr;
    logic [ADDR_W-1:0] win_mask;
    logic              blk_end;
    logic              last_word;
    logic              at_bnd;
    logic [CNT_W-1:0]  new_cnt;

    assign new_cnt   = CNT_W'(wdata[31:16]);
    assign buf_ready = (state == XS_RUN);
    assign accept    = buf_ready && buf_valid;
    assign next_addr = addr_q + ADDR_W'(STEP);
    assign win_mask  = ADDR_W'(bound_mask(cfg.bnd_code));
    assign at_bnd    = ((next_addr & win_mask) == '0);
    assign blk_end   = ({1'b0, byte_q} + 13'(STEP)) >= {1'b0, cfg.blen};
    assign last_word = blk_end && (cnt_q == CNT_W'(1));

    assign evt.done  = accept && last_word;
    assign evt.pause = accept && !last_word && at_bnd;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= XS_IDLE;
            addr_q <= '0;
            cnt_q  <= '0;
            byte_q <= '0;
        end else begin
            unique case (state)
                XS_IDLE: begin
                    if (wr_sys) begin
                        addr_q <= wdata[ADDR_W-1:0];
                    end
                    if (wr_blk) begin
                        cnt_q  <= new_cnt;
                        byte_q <= '0;
                        if (new_cnt != '0) begin
                            state <= XS_RUN;
                        end
                    end
                end
                XS_RUN: begin
                    if (accept) begin
                        addr_q <= next_addr;
                        if (blk_end) begin
                            byte_q <= '0;
                            cnt_q  <= cnt_q - CNT_W'(1);
                        end else begin
                            byte_q <= byte_q + 12'(STEP);
                        end
                        if (last_word) begin
                            state <= XS_IDLE;
                        end else if (at_bnd) begin
                            state <= XS_PAUSE;
                        end
                    end
                end
                XS_PAUSE: begin
                    if (wr_sys) begin
                        addr_q <= wdata[ADDR_W-1:0];
                        state  <= XS_RUN;
                    end
                end
                default: state <= XS_IDLE;
            endcase
        end
    end

    assign cur_addr = addr_q;
    assign blk_cnt  = cnt_q;
    assign idle     = (state == XS_IDLE);

    // R4: each taken word moves the address by one word
    p_step_r4: assert property (@(posedge clk) disable iff (rst)
        accept |=> (cur_addr == $past(cur_addr) + ADDR_W'(STEP)));

    // R7: a pause holds the address until software writes it
    p_pause_freeze_r7: assert property (@(posedge clk) disable iff (rst)
        (state == XS_PAUSE && !wr_sys) |=> ($stable(cur_addr) && state == XS_PAUSE));

    // R5: an active transfer always has blocks left
    p_run_cnt_r5: assert property (@(posedge clk) disable iff (rst)
        (state != XS_IDLE) |-> (blk_cnt != '0));

    // R6: completion returns the engine to idle
    p_done_idle_r6: assert property (@(posedge clk) disable iff (rst)
        evt.done |=> idle);

endmodule

// File: rtl/sdma_wr_port.sv
module sdma_wr_port #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              mem_wr_valid,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [DATA_W-1:0] mem_wr_data
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_wr_valid <= 1'b0;
            mem_wr_addr  <= '0;
            mem_wr_data  <= '0;
        end else begin
            mem_wr_valid <= accept;
            if (accept) begin
                mem_wr_addr <= addr_i;
                mem_wr_data <= data_i;
            end
        end
    end

    // R4: a write request follows a taken word and carries its address
    p_wr_follow_r4: assert property (@(posedge clk) disable iff (rst)
        accept |=> (mem_wr_valid && mem_wr_addr == $past(addr_i)));

    // R7: no write request without a taken word
    p_wr_needs_accept_r7: assert property (@(posedge clk) disable iff (rst)
        mem_wr_valid |-> $past(accept));

endmodule

// File: rtl/sdma_engine.sv
module sdma_engine
    import sdma_pkg::*;
#(
    parameter int unsigned REG_AW = 16,
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              buf_valid,
    input  logic [DATA_W-1:0] buf_data,
    output logic              buf_ready,
    output logic              mem_wr_valid,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [DATA_W-1:0] mem_wr_data,
    output logic              irq
);

    logic              unused_addr_hi;
    logic              wr_sys;
    logic              wr_blk;
    logic              idle;
    logic              accept;
    logic [ADDR_W-1:0] cur_addr;
    logic [CNT_W-1:0]  blk_cnt;
    blk_cfg_t          cfg;
    xfer_evt_t         evt;

    // The 256-byte window repeats; upper address bits are not decoded.
    assign unused_addr_hi = ^reg_addr[REG_AW-1:8];

    sdma_regfile #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W)
    ) regs_i (
        .clk      (clk),
        .rst      (rst),
        .off      (reg_addr[7:0]),
        .reg_wr   (reg_wr),
        .wdata_lo (reg_wdata[15:0]),
        .idle     (idle),
        .cur_addr (cur_addr),
        .blk_cnt  (blk_cnt),
        .evt      (evt),
        .wr_sys   (wr_sys),
        .wr_blk   (wr_blk),
        .cfg      (cfg),
        .rdata    (reg_rdata),
        .irq      (irq)
    );

    sdma_xfer_ctrl #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) ctrl_i (
        .clk       (clk),
        .rst       (rst),
        .wr_sys    (wr_sys),
        .wr_blk    (wr_blk),
        .wdata     (reg_wdata),
        .cfg       (cfg),
        .buf_valid (buf_valid),
        .buf_ready (buf_ready),
        .accept    (accept),
        .cur_addr  (cur_addr),
        .blk_cnt   (blk_cnt),
        .idle      (idle),
        .evt       (evt)
    );

    sdma_wr_port #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) wport_i (
        .clk          (clk),
        .rst          (rst),
        .accept       (accept),
        .addr_i       (cur_addr),
        .data_i       (buf_data),
        .mem_wr_valid (mem_wr_valid),
        .mem_wr_addr  (mem_wr_addr),
        .mem_wr_data  (mem_wr_data)
    );

    // R10: irq only while a status bit is pending
    p_irq_idle_r10: assert property (@(posedge clk) disable iff (rst)
        (irq && !$past(irq)) |-> $past(evt.done || evt.pause));

endmodule

// File: tb/sdma_engine_tb.sv
`timescale 1ns/1ps
module sdma_engine_tb_top;

    localparam logic [7:0] O_SYS = 8'h00;
    localparam logic [7:0] O_BLK = 8'h04;
    localparam logic [7:0] O_STS = 8'h30;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        buf_valid = 1'b0;
    logic [31:0] buf_data = '0;
    logic        buf_ready;
    logic        mem_wr_valid;
    logic [31:0] mem_wr_addr;
    logic [31:0] mem_wr_data;
    logic        irq;

    int tests = 0;
    int fails = 0;
    int unsigned seed_v;

    always #2 clk = ~clk;

    sdma_engine dut_i (
        .clk          (clk),
        .rst          (rst),
        .reg_addr     (reg_addr),
        .reg_wr       (reg_wr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .buf_valid    (buf_valid),
        .buf_data     (buf_data),
        .buf_ready    (buf_ready),
        .mem_wr_valid (mem_wr_valid),
        .mem_wr_addr  (mem_wr_addr),
        .mem_wr_data  (mem_wr_data),
        .irq          (irq)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic reg_write(input logic [7:0] off, input logic [31:0] d);
        @(negedge clk);
        reg_addr  = {8'($urandom), off};
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic reg_read(input logic [7:0] off, output logic [31:0] d);
        reg_addr = {8'($urandom), off};
        #1;
        d = reg_rdata;
    endtask

    function automatic logic [31:0] bsize_of(input logic [2:0] code);
        return 32'h1000 << code;
    endfunction

    task automatic run_xfer(input logic [31:0] start, input logic [2:0] code,
                            input logic [11:0] blen, input logic [15:0] cnt,
                            input bit poke_running);
        logic [31:0] bsz;
        logic [31:0] exp_a;
        logic [31:0] rd;
        logic [31:0] d;
        int wpb;
        int total;
        bsz   = bsize_of(code);
        wpb   = int'(blen) / 4;
        total = wpb * int'(cnt);
        reg_write(O_SYS, start);
        reg_write(O_BLK, {cnt, 1'b0, code, blen});
        chk("R3", "ready after arm", 32'(buf_ready), 32'd1);
        exp_a = start;
        for (int w = 0; w < total; w++) begin
            repeat ($urandom % 3) @(negedge clk);
            if (poke_running && w == 1) begin
                reg_write(O_SYS, 32'hDEAD_0000);
                reg_write(O_BLK, 32'h0001_0004);
                reg_read(O_SYS, rd);
                chk("R11", "sysaddr write while running", rd, exp_a);
            end
            d = $urandom;
            buf_valid = 1'b1;
            buf_data  = d;
            @(negedge clk);
            buf_valid = 1'b0;
            chk("R4", "write valid", 32'(mem_wr_valid), 32'd1);
            chk("R4", "write addr", mem_wr_addr, exp_a);
            chk("R4", "write data", mem_wr_data, d);
            exp_a = exp_a + 32'd4;
            if (w == total - 1) begin
                reg_read(O_STS, rd);
                chk("R9", "status at completion", rd, 32'h2);
                chk("R6", "ready low after completion", 32'(buf_ready), 32'd0);
                reg_read(O_BLK, rd);
                chk("R6", "count zero", 32'(rd[31:16]), 32'd0);
                chk("R10", "irq on completion", 32'(irq), 32'd1);
            end else begin
                if ((w + 1) % wpb == 0) begin
                    reg_read(O_BLK, rd);
                    chk("R5", "blocks left", 32'(rd[31:16]),
                        32'(int'(cnt) - (w + 1) / wpb));
                end
                if ((exp_a & (bsz - 32'd1)) == 32'd0) begin
                    chk("R7", "ready low at boundary", 32'(buf_ready), 32'd0);
                    reg_read(O_STS, rd);
                    chk("R7", "dma status", rd, 32'h8);
                    reg_read(O_SYS, rd);
                    chk("R7", "paused address", rd, exp_a);
                    buf_valid = 1'b1;
                    buf_data  = 32'hBAD0_BAD0;
                    for (int k = 0; k < 3; k++) begin
                        @(negedge clk);
                        chk("R7", "no write while paused", 32'(mem_wr_valid), 32'd0);
                    end
                    buf_valid = 1'b0;
                    reg_write(O_STS, 32'h0);
                    reg_read(O_STS, rd);
                    chk("R10", "write 0 keeps status", rd, 32'h8);
                    reg_write(O_STS, 32'h8);
                    reg_read(O_STS, rd);
                    chk("R10", "w1c clears dma", rd, 32'h0);
                    chk("R10", "irq low after clear", 32'(irq), 32'd0);
                    if ($urandom % 2 == 0) begin
                        exp_a = bsz * (32'd8 + ($urandom % 8)) - 32'd4 * ($urandom % 4);
                    end
                    reg_write(O_SYS, exp_a);
                    chk("R8", "ready after resume", 32'(buf_ready), 32'd1);
                end else begin
                    chk("R7", "ready mid window", 32'(buf_ready), 32'd1);
                end
            end
        end
        reg_write(O_STS, 32'h2);
        reg_read(O_STS, rd);
        chk("R10", "w1c clears done", rd, 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        logic [2:0]  code;
        logic [31:0] bsz;
        seed_v = $urandom(32'd20240611);
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        reg_read(O_SYS, rd); chk("R1", "sysaddr reset", rd, 32'h0);
        reg_read(O_BLK, rd); chk("R1", "blk reset", rd, 32'h0);
        reg_read(O_STS, rd); chk("R1", "status reset", rd, 32'h0);
        chk("R1", "ready reset", 32'(buf_ready), 32'd0);
        chk("R1", "wr valid reset", 32'(mem_wr_valid), 32'd0);
        chk("R1", "irq reset", 32'(irq), 32'd0);

        // R2: mirrored window, unmapped offsets
        reg_write(O_SYS, 32'h1234_5670);
        reg_addr = 16'hA700; #1;
        chk("R2", "mirror read", reg_rdata, 32'h1234_5670);
        reg_write(8'h08, 32'hFFFF_FFFF);
        reg_read(8'h08, rd); chk("R2", "unmapped reads zero", rd, 32'h0);
        reg_read(O_SYS, rd); chk("R2", "unmapped write no effect", rd, 32'h1234_5670);

        // R3: zero count does not start
        reg_write(O_BLK, 32'h0000_0008);
        chk("R3", "zero count stays idle", 32'(buf_ready), 32'd0);

        // R9: last word lands on a 4 KiB edge
        run_xfer(32'h0000_1000 - 32'd16, 3'd0, 12'd8, 16'd2, 1'b0);
        // R7/R8/R11: pause mid-block with writes while running
        run_xfer(32'h0000_2000 - 32'd8, 3'd0, 12'd16, 16'd3, 1'b1);
        // R7: largest boundary code
        run_xfer(32'h0018_0000 - 32'd8, 3'd7, 12'd4, 16'd5, 1'b0);

        for (int t = 0; t < 20; t++) begin
            code = 3'($urandom % 3);
            bsz  = bsize_of(code);
            run_xfer(bsz * (32'd1 + ($urandom % 16)) - 32'd4 * ($urandom % 24),
                     code, 12'(4 * (1 + $urandom % 8)), 16'(1 + $urandom % 6),
                     ($urandom % 4) == 0);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule